// File: doc/BRIEF.md
# Iterative Integer Divider with Condition Flags

This block divides a 32-bit dividend by a 32-bit divisor for a processor datapath. It can treat both operands as unsigned or as two's-complement values. A word-result mode asks whether the quotient fits in 16 bits. The block always returns the full 32-bit quotient and remainder. Alongside them it returns negative, zero and overflow condition flags and a divide-by-zero exception indication. Each result is marked by a one-cycle completion pulse.

The block takes the absolute values of the operands and runs a restoring shift-subtract loop over them, one quotient bit per clock. It then applies the signs and computes the flags. A zero divisor skips the loop entirely: the block reports the exception and leaves the previous results in place. The surrounding pipeline raises the start strobe once per divide and waits for the completion pulse. It then reads the results, which stay valid until the next completion.

Top module: `div_cc_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first completion, quotient, remainder, all three flags, the exception output and the completion pulse are all 0.
- R2: With `sgn_i`=0 the operands are unsigned. The quotient is floor(dividend/divisor) and the remainder is dividend minus quotient times divisor, both 32 bits wide.
- R3: With `sgn_i`=1 the operands are two's complement. The quotient truncates toward zero and a nonzero remainder carries the dividend's sign. The case 0x80000000 / 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R4: `flag_z_o` is 1 exactly when the 32-bit quotient is zero.
- R5: `flag_n_o` is 1 exactly when the quotient is nonzero and its bit 31 is 1.
- R6: With `word_i`=1 and `sgn_i`=0, `flag_v_o` is 1 exactly when the quotient is above 0xFFFF. With `word_i`=0, `flag_v_o` is 0 in both signedness modes.
- R7: With `word_i`=1 and `sgn_i`=1, `flag_v_o` is 1 exactly when the quotient lies outside -32768..32767.
- R8: A zero divisor sets `dz_o` to 1 and completes two cycles after the accepting edge. Quotient, remainder and flags keep their previous values.
- R9: For a nonzero divisor, `done_o` is high for exactly one cycle, 33 clock edges after the edge that accepts the start. All outputs hold their values between completions.
- R10: A start strobe that arrives while a divide is in progress is ignored. The running divide finishes on its original schedule with its original operands.
- R11: Each completion with a nonzero divisor clears `dz_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| dvd_i | input | 32 | Dividend |
| dvs_i | input | 32 | Divisor |
| sgn_i | input | 1 | 1 = signed, 0 = unsigned |
| word_i | input | 1 | 1 = 16-bit result overflow check |
| quo_o | output | 32 | Quotient |
| rem_o | output | 32 | Remainder |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Word overflow flag |
| dz_o | output | 1 | Divide-by-zero exception |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench covers every sign combination of the operands.
- A sign correction applied to the wrong result would give a remainder with the divisor's sign.
- Dividends at 0x80000000 and above expose a restoring step that loses the carry-out of the shifted partial remainder.
- Quotients just on each side of 0xFFFF, 0x7FFF and -0x8000 catch a word overflow test that uses the wrong signedness or is off by one.
- The most negative dividend divided by -1 must give 0x80000000 with N set and V clear.

A zero divisor is checked to leave the prior results untouched and to raise the exception; the next normal divide must clear it. A start strobe sent mid-divide must not restart or corrupt the running divide.

// File: rtl/div_cc_pkg.sv
package div_cc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } dstate_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
  } ccflags_t;

  typedef struct packed {
    logic sgn;
    logic word;
    logic neg_q;
    logic neg_r;
    logic dz;
  } dctx_t;

endpackage

// File: rtl/div_cc_prep.sv
module div_cc_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  input  logic         sgn,
  output logic [W-1:0] mag_dvd,
  output logic [W-1:0] mag_dvs,
  output logic         neg_q,
  output logic         neg_r,
  output logic         dvs_zero
);
  logic dvd_neg, dvs_neg;

  always_comb begin
    dvd_neg  = sgn & dvd[W-1];
    dvs_neg  = sgn & dvs[W-1];
    mag_dvd  = dvd_neg ? (~dvd + 1'b1) : dvd;
    mag_dvs  = dvs_neg ? (~dvs + 1'b1) : dvs;
    neg_q    = dvd_neg ^ dvs_neg;
    neg_r    = dvd_neg;
    dvs_zero = ~|dvs;
  end
endmodule

// File: rtl/div_cc_ctrl.sv
module div_cc_ctrl
  import div_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic dvs_zero,
  output logic load,
  output logic step,
  output logic fin
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  dstate_e       state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    step    = 1'b0;
    fin     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          cnt_d   = '0;
          state_d = dvs_zero ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        step  = 1'b1;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIN;
      end
      ST_FIN: begin
        fin     = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/div_cc_core.sv
module div_cc_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] mag_dvd,
  input  logic [W-1:0] mag_dvs,
  output logic [W-1:0] quo_mag,
  output logic [W-1:0] rem_mag
);
  logic [W-1:0] rem_q, rem_d, quo_q, quo_d, dvs_q, dvs_d;
  logic [W:0]   trial;
  logic         fits;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    fits  = trial >= {1'b0, dvs_q};
    rem_d = rem_q;
    quo_d = quo_q;
    dvs_d = dvs_q;
    if (load) begin
      rem_d = '0;
      quo_d = mag_dvd;
      dvs_d = mag_dvs;
    end else if (step) begin
      rem_d = fits ? (trial[W-1:0] - dvs_q) : trial[W-1:0];
      quo_d = {quo_q[W-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load || step) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
    end
  end

  assign quo_mag = quo_q;
  assign rem_mag = rem_q;
endmodule

// File: rtl/div_cc_fin.sv
module div_cc_fin
  import div_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  input  dctx_t        ctx,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output ccflags_t     flags
);
  localparam int HALF = W / 2;

  logic [W-HALF-1:0] hi_u;
  logic [W-HALF:0]   hi_s;
  logic              ovf_u, ovf_s;

  always_comb begin
    quo     = ctx.neg_q ? (~quo_mag + 1'b1) : quo_mag;
    rem     = ctx.neg_r ? (~rem_mag + 1'b1) : rem_mag;
    hi_u    = quo[W-1:HALF];
    hi_s    = quo[W-1:HALF-1];
    ovf_u   = |hi_u;
    ovf_s   = !((&hi_s) || !(|hi_s));
    flags.z = ~|quo;
    flags.n = (|quo) & quo[W-1];
    flags.v = ctx.word & (ctx.sgn ? ovf_s : ovf_u);
  end
endmodule

// File: rtl/div_cc_unit.sv
module div_cc_unit
  import div_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  input  logic         sgn_i,
  input  logic         word_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         flag_n_o,
  output logic         flag_z_o,
  output logic         flag_v_o,
  output logic         dz_o,
  output logic         done_o
);
  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  logic [W-1:0] mag_dvd, mag_dvs, quo_mag, rem_mag, quo_fix, rem_fix;
  logic         neg_q, neg_r, dvs_zero, load, step, fin;
  dctx_t        ctx_q, ctx_d;
  ccflags_t     flg_fix, flg_q, flg_d;
  logic [W-1:0] quo_q, quo_d, rem_q, rem_d;
  logic         dz_q, dz_d, done_q;

  div_cc_prep #(.W(W)) u_prep (
    .dvd(dvd_i), .dvs(dvs_i), .sgn(sgn_i),
    .mag_dvd(mag_dvd), .mag_dvs(mag_dvs),
    .neg_q(neg_q), .neg_r(neg_r), .dvs_zero(dvs_zero)
  );

  div_cc_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .start(start_i), .dvs_zero(dvs_zero),
    .load(load), .step(step), .fin(fin)
  );

  div_cc_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_sn), .load(load), .step(step),
    .mag_dvd(mag_dvd), .mag_dvs(mag_dvs),
    .quo_mag(quo_mag), .rem_mag(rem_mag)
  );

  div_cc_fin #(.W(W)) u_fin (
    .quo_mag(quo_mag), .rem_mag(rem_mag), .ctx(ctx_q),
    .quo(quo_fix), .rem(rem_fix), .flags(flg_fix)
  );

  always_comb begin
    ctx_d = ctx_q;
    if (load) begin
      ctx_d.sgn   = sgn_i;
      ctx_d.word  = word_i;
      ctx_d.neg_q = neg_q;
      ctx_d.neg_r = neg_r;
      ctx_d.dz    = dvs_zero;
    end
    quo_d = quo_q;
    rem_d = rem_q;
    flg_d = flg_q;
    dz_d  = dz_q;
    if (fin) begin
      dz_d = ctx_q.dz;
      if (!ctx_q.dz) begin
        quo_d = quo_fix;
        rem_d = rem_fix;
        flg_d = flg_fix;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctx_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      flg_q  <= '0;
      dz_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (load) ctx_q <= ctx_d;
      if (fin) begin
        quo_q <= quo_d;
        rem_q <= rem_d;
        flg_q <= flg_d;
        dz_q  <= dz_d;
      end
      done_q <= fin;
    end
  end

  assign quo_o    = quo_q;
  assign rem_o    = rem_q;
  assign flag_n_o = flg_q.n;
  assign flag_z_o = flg_q.z;
  assign flag_v_o = flg_q.v;
  assign dz_o     = dz_q;
  assign done_o   = done_q;
endmodule

// File: rtl/div_cc_chk.sv
module div_cc_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] quo_o,
  input logic [W-1:0] rem_o,
  input logic         flag_n_o,
  input logic         flag_z_o,
  input logic         flag_v_o,
  input logic         dz_o,
  input logic         done_o
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(quo_o) && $stable(rem_o) &&
                 $stable({flag_n_o, flag_z_o, flag_v_o, dz_o})));

  // R8
  dz_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dz_o) |-> done_o);

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !dz_o) |-> (flag_z_o == (quo_o == '0)));

  // R5
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !dz_o) |-> (flag_n_o == quo_o[W-1]));

  // R5
  nz_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_n_o && flag_z_o));
endmodule

bind div_cc_unit div_cc_chk #(.W(W)) u_div_cc_chk (
  .clk(clk), .rst_n(rst_n), .quo_o(quo_o), .rem_o(rem_o),
  .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_v_o(flag_v_o),
  .dz_o(dz_o), .done_o(done_o)
);

// File: tb/tb_div_cc_unit.sv
module tb_div_cc_unit;
  localparam int W      = 32;
  localparam int PERIOD = 10;
  localparam int LAT    = W + 2;
  localparam int NV     = 19;

  // {dvd, dvs, sgn, word, quo, rem, n, z, v}
  localparam logic [132:0] VEC [NV] = '{
    {32'h00000064, 32'h00000007, 1'b0, 1'b0, 32'h0000000E, 32'h00000002, 1'b0, 1'b0, 1'b0},
    {32'hFFFFFF9C, 32'h00000007, 1'b1, 1'b0, 32'hFFFFFFF2, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b0},
    {32'h00000064, 32'hFFFFFFF9, 1'b1, 1'b0, 32'hFFFFFFF2, 32'h00000002, 1'b1, 1'b0, 1'b0},
    {32'hFFFFFF9C, 32'hFFFFFFF9, 1'b1, 1'b0, 32'h0000000E, 32'hFFFFFFFE, 1'b0, 1'b0, 1'b0},
    {32'h00000003, 32'h0000000A, 1'b0, 1'b0, 32'h00000000, 32'h00000003, 1'b0, 1'b1, 1'b0},
    {32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 1'b0},
    {32'hFFFFFF9C, 32'h00000007, 1'b0, 1'b0, 32'h24924916, 32'h00000002, 1'b0, 1'b0, 1'b0},
    {32'h80000000, 32'h80000001, 1'b0, 1'b0, 32'h00000000, 32'h80000000, 1'b0, 1'b1, 1'b0},
    {32'hFFFFFFFF, 32'h80000000, 1'b0, 1'b0, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b0, 1'b0},
    {32'h00010000, 32'h00000001, 1'b0, 1'b1, 32'h00010000, 32'h00000000, 1'b0, 1'b0, 1'b1},
    {32'h0000FFFF, 32'h00000001, 1'b0, 1'b1, 32'h0000FFFF, 32'h00000000, 1'b0, 1'b0, 1'b0},
    {32'h00012345, 32'h00000010, 1'b0, 1'b1, 32'h00001234, 32'h00000005, 1'b0, 1'b0, 1'b0},
    {32'h00008000, 32'h00000001, 1'b1, 1'b1, 32'h00008000, 32'h00000000, 1'b0, 1'b0, 1'b1},
    {32'h00007FFF, 32'h00000001, 1'b1, 1'b1, 32'h00007FFF, 32'h00000000, 1'b0, 1'b0, 1'b0},
    {32'hFFFF8000, 32'h00000001, 1'b1, 1'b1, 32'hFFFF8000, 32'h00000000, 1'b1, 1'b0, 1'b0},
    {32'hFFFF7FFF, 32'h00000001, 1'b1, 1'b1, 32'hFFFF7FFF, 32'h00000000, 1'b1, 1'b0, 1'b1},
    {32'h00000005, 32'hFFFFFFFF, 1'b1, 1'b1, 32'hFFFFFFFB, 32'h00000000, 1'b1, 1'b0, 1'b0},
    {32'h00100000, 32'h00000002, 1'b1, 1'b1, 32'h00080000, 32'h00000000, 1'b0, 1'b0, 1'b1},
    {32'h80000000, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h80000000, 32'h00000000, 1'b1, 1'b0, 1'b0}
  };

  logic         clk, rst_n, start_i, sgn_i, word_i;
  logic [W-1:0] dvd_i, dvs_i, quo_o, rem_o;
  logic         flag_n_o, flag_z_o, flag_v_o, dz_o, done_o;
  int           checks, failures;

  div_cc_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dvd_i(dvd_i), .dvs_i(dvs_i),
    .sgn_i(sgn_i), .word_i(word_i), .quo_o(quo_o), .rem_o(rem_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_v_o(flag_v_o),
    .dz_o(dz_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drives a start at a negedge and waits for done; returns cycles seen.
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic s, input logic w, output int lat);
    dvd_i = a; dvs_i = b; sgn_i = s; word_i = w; start_i = 1'b1;
    lat = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      lat++;
      start_i = 1'b0;
      if (done_o) break;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    logic [W-1:0] pq, pr;
    logic [2:0]   pf;
    checks = 0; failures = 0;
    rst_n = 1'b0; start_i = 1'b0; dvd_i = '0; dvs_i = '0; sgn_i = 1'b0; word_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(quo_o == 0 && rem_o == 0 && done_o == 0 && dz_o == 0, "R1", "reset outs",
        quo_o, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: after release, before first completion
    chk({flag_n_o, flag_z_o, flag_v_o, dz_o, done_o} == 0 && quo_o == 0 && rem_o == 0,
        "R1", "post-reset outs", {27'h0, flag_n_o, flag_z_o, flag_v_o, dz_o, done_o}, 32'h0);

    // R2 R3 R4 R5 R6 R7 R9: vector table
    for (int i = 0; i < NV; i++) begin
      logic [132:0] v;
      v = VEC[i];
      run(v[132:101], v[100:69], v[68], v[67], lat);
      chk(lat == LAT, "R9", $sformatf("latency vec %0d", i), 32'(lat), 32'(LAT));
      chk(quo_o == v[66:35], v[68] ? "R3" : "R2", $sformatf("quotient vec %0d", i),
          quo_o, v[66:35]);
      chk(rem_o == v[34:3], v[68] ? "R3" : "R2", $sformatf("remainder vec %0d", i),
          rem_o, v[34:3]);
      chk(flag_z_o == v[1], "R4", $sformatf("Z vec %0d", i), 32'(flag_z_o), 32'(v[1]));
      chk(flag_n_o == v[2], "R5", $sformatf("N vec %0d", i), 32'(flag_n_o), 32'(v[2]));
      chk(flag_v_o == v[0], v[68] ? "R7" : "R6", $sformatf("V vec %0d", i),
          32'(flag_v_o), 32'(v[0]));
      chk(dz_o == 1'b0, "R11", $sformatf("dz clear vec %0d", i), 32'(dz_o), 32'h0);
    end

    // R9: single-cycle pulse and held outputs afterwards
    pq = quo_o; pr = rem_o; pf = {flag_n_o, flag_z_o, flag_v_o};
    @(negedge clk);
    chk(done_o == 1'b0, "R9", "done single pulse", 32'(done_o), 32'h0);
    repeat (5) @(negedge clk);
    chk(quo_o == pq && rem_o == pr && {flag_n_o, flag_z_o, flag_v_o} == pf, "R9",
        "outputs held", quo_o, pq);

    // R8: zero divisor keeps previous results, raises exception
    run(32'h00000005, 32'h0, 1'b1, 1'b1, lat);
    chk(lat == 2, "R8", "dz latency", 32'(lat), 32'h2);
    chk(dz_o == 1'b1, "R8", "dz raised", 32'(dz_o), 32'h1);
    chk(quo_o == pq, "R8", "quotient kept", quo_o, pq);
    chk(rem_o == pr, "R8", "remainder kept", rem_o, pr);
    chk({flag_n_o, flag_z_o, flag_v_o} == pf, "R8", "flags kept",
        32'({flag_n_o, flag_z_o, flag_v_o}), 32'(pf));
    repeat (3) @(negedge clk);
    chk(dz_o == 1'b1, "R8", "dz held", 32'(dz_o), 32'h1);

    // R11: next normal divide clears the exception
    run(32'h00000009, 32'h00000003, 1'b0, 1'b0, lat);
    chk(dz_o == 1'b0, "R11", "dz cleared", 32'(dz_o), 32'h0);
    chk(quo_o == 32'h3 && rem_o == 32'h0, "R11", "result after dz", quo_o, 32'h3);

    // R10: start during a running divide is ignored
    dvd_i = 32'h00000064; dvs_i = 32'h00000007; sgn_i = 1'b0; word_i = 1'b0;
    start_i = 1'b1;
    lat = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      lat++;
      if (lat == 6) begin
        start_i = 1'b1; dvd_i = 32'h00000009; dvs_i = 32'h00000000; sgn_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      if (done_o) break;
    end
    chk(lat == LAT, "R10", "busy start latency", 32'(lat), 32'(LAT));
    chk(quo_o == 32'hE, "R10", "busy start quotient", quo_o, 32'hE);
    chk(rem_o == 32'h2, "R10", "busy start remainder", rem_o, 32'h2);
    chk(dz_o == 1'b0, "R10", "busy start no dz", 32'(dz_o), 32'h0);
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0 && quo_o == 32'hE, "R10", "no extra completion", quo_o, 32'hE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule